// File: doc/BRIEF.md
# Bidirectional Command Mailbox

This block carries short commands between an external host and an on-chip processor. The commands do not pass through the bulk data FIFOs. There are two independent one-byte registers, one for each direction. The host loads the inbound register. It does this through the same write strobe it uses for the FIFO data port, and a single select input decides where each host access goes. The on-chip processor loads the outbound register.

For each direction, the receiver sees a pending flag and the sender sees a room flag. A receiver that reads its register empties it, so the sender can post the next command. Each receiver has its own interrupt enable. With the enable low, the receiver polls the pending flag instead. A write that arrives while the register still holds an unread command is dropped, and it raises a sticky error flag on the writer's side. All status changes take effect on the clock edge after the access.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous active-low reset, both registers are empty: `host_cmd_room` and `cpu_cmd_room` are 1, `cpu_cmd_pend` and `host_cmd_pend` are 0, both error flags are 0 and both interrupts are 0.
- R2: A host write with `host_cmd_sel`=1 into an empty inbound register stores `host_wdata`. From the next edge on, `cpu_cmd_pend`=1, `host_cmd_room`=0 and `cpu_rdata` shows the stored byte.
- R3: With `host_cmd_sel`=0, a host write asserts `fifo_wr` in the same cycle with `fifo_wdata`=`host_wdata`, and a host read asserts `fifo_rd` in the same cycle. Neither access changes either mailbox.
- R4: A processor write into an empty outbound register stores `cpu_wdata`. From the next edge on, `host_cmd_pend`=1, `cpu_cmd_room`=0 and `host_rdata` shows the byte.
- R5: A receiver read of a full register empties it from the next edge on. For the inbound register this is a `cpu_rd`; for the outbound register it is a `host_rd` with `host_cmd_sel`=1. The receiver's pending flag goes to 0 and the sender's room flag goes to 1.
- R6: A write into a full register is dropped, and the stored byte is kept. The writer's error flag (`host_err` for inbound, `cpu_err` for outbound) is 1 from the next edge and stays 1 until reset.
- R7: `cpu_irq` equals `cpu_cmd_pend` AND `cpu_ie`, and `host_irq` equals `host_cmd_pend` AND `host_ie`. Each interrupt falls on the edge that follows the read that empties its register.
- R8: A receiver read of an empty register changes no flag and no stored byte.
- R9: When a write and a read reach a full register in the same cycle, the read empties it and the write is dropped with the error flag set. The data output keeps the old byte.
- R10: The two registers are independent: an access to one never changes the flags or data of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_cmd_sel | input | 1 | Host target: 1 = command register, 0 = FIFO data port |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Outbound command byte |
| host_ie | input | 1 | Host interrupt enable |
| host_irq | output | 1 | Host interrupt: outbound command pending |
| host_cmd_pend | output | 1 | Outbound register holds an unread command |
| host_cmd_room | output | 1 | Inbound register can accept a command |
| host_err | output | 1 | Sticky: host wrote into a full inbound register |
| fifo_wr | output | 1 | Write strobe forwarded to the FIFO data port |
| fifo_wdata | output | W | Data forwarded to the FIFO data port |
| fifo_rd | output | 1 | Read strobe forwarded to the FIFO data port |
| cpu_wr | input | 1 | Processor writes the outbound register |
| cpu_rd | input | 1 | Processor reads the inbound register |
| cpu_wdata | input | W | Processor write data |
| cpu_rdata | output | W | Inbound command byte |
| cpu_ie | input | 1 | Processor interrupt enable |
| cpu_irq | output | 1 | Processor interrupt: inbound command pending |
| cpu_cmd_pend | output | 1 | Inbound register holds an unread command |
| cpu_cmd_room | output | 1 | Outbound register can accept a command |
| cpu_err | output | 1 | Sticky: processor wrote into a full outbound register |

## Verification
A wrong full bit shows at the ports one edge after the access that corrupted it. It appears as a pending flag and a room flag that disagree with the access history, and it drags the interrupt with it at once. A lost or overwritten byte shows on the receiver's data output as soon as the register is loaded. A misrouted host access shows in the same cycle as a FIFO strobe that should not be there, or as a strobe that is missing. The bench samples every flag one cycle after each access, and it drives collisions and cross-direction traffic so that coupling between the two registers becomes visible.

// File: rtl/mbx_pkg.sv
// Shared definitions for the command mailbox.
// Assumes: index 0 is the host-to-processor direction, index 1 the reverse.
package mbx_pkg;
    localparam int unsigned NUM_DIR = 2;
    localparam int unsigned DIR_IN  = 0;
    localparam int unsigned DIR_OUT = 1;

    typedef enum logic {
        HSEL_FIFO = 1'b0,
        HSEL_CMD  = 1'b1
    } host_sel_e;
endpackage

// File: rtl/mbx_slot.sv
// One single-entry command register with full flag, sticky write error
// and masked interrupt.
// Assumes: wr and rd are single-cycle strobes; a read in the same cycle
// as a write on a full slot wins and the write is rejected.
module mbx_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    input  logic         ie,
    output logic [W-1:0] data,
    output logic         full,
    output logic         err,
    output logic         irq
);
    logic wr_take;
    logic rd_take;

    // Qualify strobes against the current occupancy.
    always_comb begin
        wr_take = wr && !full;
        rd_take = rd && full;
    end

    // Hold the stored byte, occupancy and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (wr_take)
                data <= wdata;
            if (rd_take)
                full <= 1'b0;
            else if (wr_take)
                full <= 1'b1;
            if (wr && full)
                err <= 1'b1;
        end
    end

    // Interrupt follows occupancy under the receiver's enable.
    always_comb irq = full && ie;
endmodule

// File: rtl/mbx_host_decode.sv
// Steers host strobes either to the FIFO data port or to the mailbox.
// Assumes: the select is stable for the whole cycle of the strobe.
module mbx_host_decode
    import mbx_pkg::*;
(
    input  logic host_wr,
    input  logic host_rd,
    input  logic host_cmd_sel,
    output logic mbx_wr,
    output logic mbx_rd,
    output logic fifo_wr,
    output logic fifo_rd
);
    host_sel_e sel;

    // Split each host strobe by the address select.
    always_comb begin
        sel     = host_sel_e'(host_cmd_sel);
        mbx_wr  = host_wr && (sel == HSEL_CMD);
        mbx_rd  = host_rd && (sel == HSEL_CMD);
        fifo_wr = host_wr && (sel == HSEL_FIFO);
        fifo_rd = host_rd && (sel == HSEL_FIFO);
    end
endmodule

// File: rtl/cmd_mailbox.sv
// Bidirectional one-byte command mailbox between a host and a processor.
// Assumes: both sides share clk; status is registered one edge after access.
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic         host_cmd_sel,
    input  logic [W-1:0] host_wdata,
    output logic [W-1:0] host_rdata,
    input  logic         host_ie,
    output logic         host_irq,
    output logic         host_cmd_pend,
    output logic         host_cmd_room,
    output logic         host_err,
    output logic         fifo_wr,
    output logic [W-1:0] fifo_wdata,
    output logic         fifo_rd,
    input  logic         cpu_wr,
    input  logic         cpu_rd,
    input  logic [W-1:0] cpu_wdata,
    output logic [W-1:0] cpu_rdata,
    input  logic         cpu_ie,
    output logic         cpu_irq,
    output logic         cpu_cmd_pend,
    output logic         cpu_cmd_room,
    output logic         cpu_err
);
    logic         hmbx_wr;
    logic         hmbx_rd;
    logic [NUM_DIR-1:0] s_wr, s_rd, s_ie, s_full, s_err, s_irq;
    logic [W-1:0] s_wdata [NUM_DIR];
    logic [W-1:0] s_data  [NUM_DIR];

    mbx_host_decode u_dec (
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_cmd_sel (host_cmd_sel),
        .mbx_wr       (hmbx_wr),
        .mbx_rd       (hmbx_rd),
        .fifo_wr      (fifo_wr),
        .fifo_rd      (fifo_rd)
    );

    // Forward host data to the FIFO port unchanged.
    always_comb fifo_wdata = host_wdata;

    // Map each direction's writer, reader and enable onto the slots.
    always_comb begin
        s_wr[DIR_IN]     = hmbx_wr;
        s_wdata[DIR_IN]  = host_wdata;
        s_rd[DIR_IN]     = cpu_rd;
        s_ie[DIR_IN]     = cpu_ie;
        s_wr[DIR_OUT]    = cpu_wr;
        s_wdata[DIR_OUT] = cpu_wdata;
        s_rd[DIR_OUT]    = hmbx_rd;
        s_ie[DIR_OUT]    = host_ie;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        mbx_slot #(.W(W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (s_wr[d]),
            .wdata (s_wdata[d]),
            .rd    (s_rd[d]),
            .ie    (s_ie[d]),
            .data  (s_data[d]),
            .full  (s_full[d]),
            .err   (s_err[d]),
            .irq   (s_irq[d])
        );
    end

    // Present slot state as each side's status view.
    always_comb begin
        cpu_rdata     = s_data[DIR_IN];
        cpu_cmd_pend  = s_full[DIR_IN];
        host_cmd_room = !s_full[DIR_IN];
        host_err      = s_err[DIR_IN];
        cpu_irq       = s_irq[DIR_IN];
        host_rdata    = s_data[DIR_OUT];
        host_cmd_pend = s_full[DIR_OUT];
        cpu_cmd_room  = !s_full[DIR_OUT];
        cpu_err       = s_err[DIR_OUT];
        host_irq      = s_irq[DIR_OUT];
    end
endmodule

// File: rtl/cmd_mailbox_checker.sv
// Port-level properties of the command mailbox, bound to every instance.
module cmd_mailbox_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         host_wr,
    input logic         host_rd,
    input logic         host_cmd_sel,
    input logic [W-1:0] host_wdata,
    input logic [W-1:0] host_rdata,
    input logic         host_ie,
    input logic         host_irq,
    input logic         host_cmd_pend,
    input logic         host_cmd_room,
    input logic         host_err,
    input logic         fifo_wr,
    input logic         cpu_wr,
    input logic         cpu_rd,
    input logic [W-1:0] cpu_wdata,
    input logic [W-1:0] cpu_rdata,
    input logic         cpu_ie,
    input logic         cpu_irq,
    input logic         cpu_cmd_pend,
    input logic         cpu_cmd_room,
    input logic         cpu_err
);
    a_r2_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_cmd_sel && host_cmd_room) |=> (cpu_cmd_pend && cpu_rdata == $past(host_wdata)));

    a_r4_out_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_cmd_room) |=> (host_cmd_pend && host_rdata == $past(cpu_wdata)));

    a_r3_fifo_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !cpu_rd) |=> $stable(cpu_cmd_pend));

    a_r5_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_cmd_pend) |=> host_cmd_room);

    a_r6_in_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_cmd_sel && !host_cmd_room) |=> (host_err && $stable(cpu_rdata)));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (host_err || cpu_err) |=> (host_err >= $past(host_err) && cpu_err >= $past(cpu_err)));

    a_r7_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq == (cpu_cmd_pend && cpu_ie)) && (host_irq == (host_cmd_pend && host_ie)));

    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_cmd_pend && !(host_wr && host_cmd_sel)) |=> (!cpu_cmd_pend && $stable(cpu_rdata)));
endmodule

bind cmd_mailbox cmd_mailbox_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_cmd_sel(host_cmd_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ie(host_ie), .host_irq(host_irq), .host_cmd_pend(host_cmd_pend),
    .host_cmd_room(host_cmd_room), .host_err(host_err), .fifo_wr(fifo_wr),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ie(cpu_ie), .cpu_irq(cpu_irq), .cpu_cmd_pend(cpu_cmd_pend),
    .cpu_cmd_room(cpu_cmd_room), .cpu_err(cpu_err)
);

// File: tb/cmd_mailbox_bench.sv
// Directed bench for cmd_mailbox: one task per scenario.
module cmd_mailbox_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 0, host_rd = 0, host_cmd_sel = 0, host_ie = 0;
    logic [W-1:0] host_wdata = '0;
    logic cpu_wr = 0, cpu_rd = 0, cpu_ie = 0;
    logic [W-1:0] cpu_wdata = '0;
    logic [W-1:0] host_rdata, cpu_rdata, fifo_wdata;
    logic host_irq, host_cmd_pend, host_cmd_room, host_err;
    logic fifo_wr, fifo_rd;
    logic cpu_irq, cpu_cmd_pend, cpu_cmd_room, cpu_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cmd_mailbox #(.W(W)) u_cmd_mailbox (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes, then return at the next falling edge.
    task automatic cycle(logic hw, logic hr, logic hs, logic [W-1:0] hd,
                         logic cw, logic cr, logic [W-1:0] cd);
        host_wr = hw; host_rd = hr; host_cmd_sel = hs; host_wdata = hd;
        cpu_wr = cw; cpu_rd = cr; cpu_wdata = cd;
        @(negedge clk);
        host_wr = 0; host_rd = 0; cpu_wr = 0; cpu_rd = 0;
    endtask

    task automatic t_reset();
        check("R1 host_cmd_room", host_cmd_room, 1);
        check("R1 cpu_cmd_room", cpu_cmd_room, 1);
        check("R1 cpu_cmd_pend", cpu_cmd_pend, 0);
        check("R1 host_cmd_pend", host_cmd_pend, 0);
        check("R1 errs", {host_err, cpu_err}, 0);
        check("R1 irqs", {host_irq, cpu_irq}, 0);
    endtask

    task automatic t_fifo_path();
        host_wr = 1; host_cmd_sel = 0; host_wdata = 8'h5A;
        #1;
        check("R3 fifo_wr", fifo_wr, 1);
        check("R3 fifo_wdata", fifo_wdata, 8'h5A);
        @(negedge clk);
        host_wr = 0;
        check("R3 inbound untouched", cpu_cmd_pend, 0);
        host_rd = 1;
        #1;
        check("R3 fifo_rd", fifo_rd, 1);
        @(negedge clk);
        host_rd = 0;
        check("R3 outbound untouched", host_cmd_pend, 0);
    endtask

    task automatic t_inbound();
        cycle(1, 0, 1, 8'h3C, 0, 0, 0);
        check("R2 cpu_cmd_pend", cpu_cmd_pend, 1);
        check("R2 host_cmd_room", host_cmd_room, 0);
        check("R2 cpu_rdata", cpu_rdata, 8'h3C);
        check("R7 masked irq", cpu_irq, 0);
        cpu_ie = 1; #1;
        check("R7 enabled irq", cpu_irq, 1);
        @(negedge clk);
        cycle(0, 0, 0, 0, 0, 1, 0);
        check("R5 cpu_cmd_pend", cpu_cmd_pend, 0);
        check("R5 host_cmd_room", host_cmd_room, 1);
        check("R7 irq drops", cpu_irq, 0);
        cpu_ie = 0;
    endtask

    task automatic t_outbound();
        host_ie = 1;
        cycle(0, 0, 0, 0, 1, 0, 8'hA5);
        check("R4 host_cmd_pend", host_cmd_pend, 1);
        check("R4 cpu_cmd_room", cpu_cmd_room, 0);
        check("R4 host_rdata", host_rdata, 8'hA5);
        check("R7 host_irq", host_irq, 1);
        cycle(0, 1, 0, 0, 0, 0, 0);
        check("R3 fifo read keeps outbound", host_cmd_pend, 1);
        cycle(0, 1, 1, 0, 0, 0, 0);
        check("R5 host_cmd_pend", host_cmd_pend, 0);
        check("R5 cpu_cmd_room", cpu_cmd_room, 1);
        check("R7 host_irq drops", host_irq, 0);
        host_ie = 0;
    endtask

    task automatic t_empty_read();
        cycle(0, 0, 0, 0, 0, 1, 0);
        check("R8 pend stays", cpu_cmd_pend, 0);
        check("R8 data stays", cpu_rdata, 8'h3C);
        check("R8 err stays", host_err, 0);
    endtask

    task automatic t_overrun();
        cycle(1, 0, 1, 8'h11, 0, 0, 0);
        cycle(1, 0, 1, 8'h22, 0, 0, 0);
        check("R6 data kept", cpu_rdata, 8'h11);
        check("R6 host_err", host_err, 1);
        check("R10 cpu_err unaffected", cpu_err, 0);
        check("R10 outbound unaffected", host_cmd_pend, 0);
        cycle(0, 0, 0, 0, 0, 1, 0);
        check("R6 err sticky", host_err, 1);
        check("R5 drained", cpu_cmd_pend, 0);
    endtask

    task automatic t_collide();
        cycle(0, 0, 0, 0, 1, 0, 8'h77);
        cycle(0, 1, 1, 0, 1, 0, 8'h88);
        check("R9 pend cleared", host_cmd_pend, 0);
        check("R9 cpu_err", cpu_err, 1);
        check("R9 data kept", host_rdata, 8'h77);
    endtask

    task automatic t_independent();
        cycle(1, 0, 1, 8'h6E, 1, 0, 8'h91);
        check("R10 inbound", cpu_rdata, 8'h6E);
        check("R10 outbound", host_rdata, 8'h91);
        cycle(0, 0, 0, 0, 0, 1, 0);
        check("R10 outbound stays", host_cmd_pend, 1);
        check("R10 inbound drained", cpu_cmd_pend, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fifo_path();
        t_inbound();
        t_outbound();
        t_empty_read();
        t_overrun();
        t_collide();
        t_independent();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule